// File: doc/BRIEF.md
# Password-Guarded Reset Mode Slice

This block is one slice of a reset controller that runs from a slow clock. It holds a small mode register on a single-cycle register bus. A write takes effect only when the top byte of the write data carries a fixed password and the chip-wide write-protect input is low. The mode register decides three things:

- whether a low level on the external reset pin raises a user reset request;
- whether a latched pin event raises an interrupt instead;
- how long the block drives the external reset output after a trigger.

The raw pin passes through a two-flop synchronizer before the block looks at it. Every pin-low event sets a sticky status flag. Software clears that flag by reading a status word. When software pulses the trigger input, the external reset output is held high for a power-of-two number of slow-clock cycles. A trigger that arrives while a pulse is running restarts the count from the value programmed at that moment.

Top module: `keyed_reset_mode`

## Requirements
- R1: A mode write (bus address 0) made while `wrProtect` is 1 changes no mode field.
- R2: A mode write changes the fields only when write-data bits 31:24 equal 0xA5. With any other byte there, no field changes.
- R3: Reading address 0 returns the user-reset enable in bit 0, the interrupt enable in bit 4 and the 4-bit length field N in bits 11:8. All other bits, including the password byte, read as 0. All fields are 0 after reset.
- R4: `userRstReq` is 1 while the user-reset enable is 1 and the synchronized pin is low. The pin passes through two flops, so the output rises after the second clock edge that samples the pin low. While the enable is 0, the output stays 0.
- R5: Reading address 1 returns the status flag in bit 0, with all other bits 0. The flag is set on any edge where the synchronized pin is low, whatever the mode. A read of address 1 with `busRe` high clears the flag at the next edge. When a set and a clear fall on the same edge, the set wins.
- R6: `irq` equals the status flag AND the interrupt enable AND NOT the user-reset enable.
- R7: The clock edge that samples `extTrig` high starts a pulse. From that edge on, `extRstOut` is 1 for exactly 2^(N+1) cycles, then returns to 0.
- R8: A trigger during a running pulse reloads the count to 2^(N+1), using the N held at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe (read-to-clear on status) |
| busAddr | input | 2 | Word address: 0 mode, 1 status |
| busWdata | input | 32 | Write data, password in bits 31:24 |
| busRdata | output | 32 | Combinational read data |
| wrProtect | input | 1 | Chip-wide write-protect enable |
| padRstN | input | 1 | Raw active-low external reset pin |
| extTrig | input | 1 | Request to drive the external reset |
| userRstReq | output | 1 | User reset request |
| irq | output | 1 | User-reset interrupt |
| extRstOut | output | 1 | External reset drive, active high |

## Verification
The bench targets the write gates first: writes carrying a near-miss password, and writes with the right password made while protection is high. A design that decodes the password loosely or ignores protection shows a changed mode word on readback.

It then checks pulse length at N of 0, 2 and 5, sampling every cycle. An off-by-one counter shows up as one cycle too many or too few. Retriggering with a smaller N set between the two triggers catches a design that ignores the retrigger or reloads from a stale length.

A status read made while the pin is still low must leave the flag set. A design where the clear wins loses the event.

The interrupt is checked with the user-reset enable both on and off. A design that ignores the enable's inverse gating raises `irq` alongside a user reset request.

// File: rtl/keyed_reset_pkg.sv
package keyed_reset_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 2;
  localparam int KEY_W       = 8;
  localparam int KEY_LSB     = 24;
  localparam logic [KEY_W-1:0] KEY_VALUE = 8'hA5;
  localparam int USR_EN_BIT  = 0;
  localparam int INT_EN_BIT  = 4;
  localparam int LEN_LSB     = 8;
  localparam int MODE_LEN_W  = 4;
  localparam int SYNC_STAGES = 2;
  localparam int MODE_ADDR   = 0;
  localparam int STAT_ADDR   = 1;
  localparam int CNT_W       = (1 << MODE_LEN_W) + 1;

  typedef struct packed {
    logic modeWr;
    logic statRd;
    logic trigLoad;
  } ctrlStrb_t;

  typedef struct packed {
    logic [MODE_LEN_W-1:0] lenSel;
    logic                  intEn;
    logic                  usrEn;
  } modeFields_t;
endpackage

// File: rtl/keyed_reset_sync.sv
module keyed_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/keyed_reset_ctrl.sv
module keyed_reset_ctrl
  import keyed_reset_pkg::*;
(
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [KEY_W-1:0]  keyByte,
  input  logic              wrProtect,
  input  logic              extTrig,
  output ctrlStrb_t         strb
);
  logic atMode;
  logic atStat;
  logic keyOk;

  always_comb begin
    atMode        = (busAddr == ADDR_W'(MODE_ADDR));
    atStat        = (busAddr == ADDR_W'(STAT_ADDR));
    keyOk         = (keyByte == KEY_VALUE);
    strb.modeWr   = busWe && atMode && keyOk && !wrProtect;
    strb.statRd   = busRe && atStat;
    strb.trigLoad = extTrig;
  end
endmodule

// File: rtl/keyed_reset_datapath.sv
module keyed_reset_datapath
  import keyed_reset_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              pinLevel,
  output logic [DATA_W-1:0] rdata,
  output modeFields_t       modeQ,
  output logic              userRstReq,
  output logic              irq,
  output logic              extRstOut
);
  logic                  statFlag;
  logic [CNT_W-1:0]      cnt;
  logic [CNT_W-1:0]      loadVal;
  logic [MODE_LEN_W:0]   shAmt;

  // mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
    end else if (strb.modeWr) begin
      modeQ.usrEn  <= wdata[USR_EN_BIT];
      modeQ.intEn  <= wdata[INT_EN_BIT];
      modeQ.lenSel <= wdata[LEN_LSB +: MODE_LEN_W];
    end
  end

  // sticky status flag, set dominates clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            statFlag <= 1'b0;
    else if (!pinLevel)   statFlag <= 1'b1;
    else if (strb.statRd) statFlag <= 1'b0;
  end

  // external reset length counter
  always_comb begin
    shAmt   = (MODE_LEN_W+1)'(modeQ.lenSel) + (MODE_LEN_W+1)'(1);
    loadVal = CNT_W'(1) << shAmt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strb.trigLoad) cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign extRstOut  = (cnt != '0);
  assign userRstReq = modeQ.usrEn && !pinLevel;
  assign irq        = statFlag && modeQ.intEn && !modeQ.usrEn;

  // read mux
  always_comb begin
    rdata = '0;
    if (rdAddr == ADDR_W'(MODE_ADDR)) begin
      rdata[USR_EN_BIT]             = modeQ.usrEn;
      rdata[INT_EN_BIT]             = modeQ.intEn;
      rdata[LEN_LSB +: MODE_LEN_W]  = modeQ.lenSel;
    end else if (rdAddr == ADDR_W'(STAT_ADDR)) begin
      rdata[0] = statFlag;
    end
  end

  // R4
  usr_req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    userRstReq |-> modeQ.usrEn);

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !modeQ.usrEn);

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statFlag && !strb.statRd) |=> statFlag);

  // R7
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(extRstOut) |-> ($past(cnt) == CNT_W'(1) && !$past(strb.trigLoad)));

  // R8
  retrig_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.trigLoad |=> extRstOut);
endmodule

// File: rtl/keyed_reset_mode.sv
module keyed_reset_mode
  import keyed_reset_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              wrProtect,
  input  logic              padRstN,
  input  logic              extTrig,
  output logic              userRstReq,
  output logic              irq,
  output logic              extRstOut
);
  ctrlStrb_t   strb;
  modeFields_t modeQ;
  logic        pinSync;

  keyed_reset_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (padRstN),
    .dout (pinSync)
  );

  keyed_reset_ctrl uCtrl (
    .busWe     (busWe),
    .busRe     (busRe),
    .busAddr   (busAddr),
    .keyByte   (busWdata[KEY_LSB +: KEY_W]),
    .wrProtect (wrProtect),
    .extTrig   (extTrig),
    .strb      (strb)
  );

  keyed_reset_datapath uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (busWdata),
    .rdAddr     (busAddr),
    .pinLevel   (pinSync),
    .rdata      (busRdata),
    .modeQ      (modeQ),
    .userRstReq (userRstReq),
    .irq        (irq),
    .extRstOut  (extRstOut)
  );

  // R1
  wp_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && wrProtect) |=> $stable(modeQ));

  // R2
  key_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busWdata[KEY_LSB +: KEY_W] != KEY_VALUE) |=> $stable(modeQ));
endmodule

// File: tb/tb_keyed_reset_mode.sv
module tb_keyed_reset_mode;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0, busRe = 1'b0, wrProtect = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        padRstN = 1'b1, extTrig = 1'b0;
  logic        userRstReq, irq, extRstOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 rdata, 1 userRstReq, 2 irq, 3 extRstOut
    logic [31:0] exp;
    string       req;
  } sbItem_t;
  sbItem_t sbQ[$];

  always #4 clk = ~clk;

  keyed_reset_mode dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .wrProtect(wrProtect),
    .padRstN(padRstN), .extTrig(extTrig), .userRstReq(userRstReq),
    .irq(irq), .extRstOut(extRstOut)
  );

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    while (sbQ.size() > 0) begin
      sbItem_t it;
      logic [31:0] act;
      it = sbQ.pop_front();
      case (it.kind)
        0:       act = busRdata;
        1:       act = {31'b0, userRstReq};
        2:       act = {31'b0, irq};
        default: act = {31'b0, extRstOut};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h t=%0t", it.req, it.kind, act, it.exp, $time);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string req);
    sbItem_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sbQ.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] d, input logic wp);
    busWe = 1'b1; busAddr = 2'd0; busWdata = d; wrProtect = wp;
    tick();
    busWe = 1'b0; wrProtect = 1'b0; busWdata = '0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic re, input logic [31:0] exp, input string req);
    busAddr = a; busRe = re;
    push(0, exp, req);
    tick();
    busRe = 1'b0;
  endtask

  task automatic pulseChk(input int n, input string req);
    int len;
    len = 1 << (n + 1);
    wr(32'hA500_0000 | (n << 8), 1'b0);
    extTrig = 1'b1;
    tick();
    extTrig = 1'b0;
    for (int i = 0; i < len + 2; i++) begin
      push(3, (i < len) ? 32'd1 : 32'd0, req);
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();

    // R3 reset state
    rdChk(2'd0, 1'b0, 32'h0, "R3 reset mode");
    rdChk(2'd1, 1'b0, 32'h0, "R5 reset status");
    push(1, 0, "R4 reset req"); push(2, 0, "R6 reset irq"); push(3, 0, "R7 reset drive");
    tick();

    // R3 layout, unused bits and password read as zero
    wr(32'hA5FF_FFFF, 1'b0);
    rdChk(2'd0, 1'b0, 32'h0000_0F11, "R3 field layout");
    // R2 wrong password
    wr(32'hA400_0000, 1'b0);
    rdChk(2'd0, 1'b0, 32'h0000_0F11, "R2 bad key 0xA4");
    wr(32'h5A00_0000, 1'b0);
    rdChk(2'd0, 1'b0, 32'h0000_0F11, "R2 bad key 0x5A");
    // R1 write protect
    wr(32'hA500_0000, 1'b1);
    rdChk(2'd0, 1'b0, 32'h0000_0F11, "R1 protected write");
    wr(32'hA500_0000, 1'b0);
    rdChk(2'd0, 1'b0, 32'h0, "R2 good key clears");

    // R4 user reset with enable on, two-flop latency
    wr(32'hA500_0001, 1'b0);
    padRstN = 1'b0;
    tick(); push(1, 0, "R4 one edge latency");
    tick(); push(1, 1, "R4 request after two edges");
    tick();
    padRstN = 1'b1;
    tick(); push(1, 1, "R4 release latency");
    tick(); push(1, 0, "R4 request drops");
    push(2, 0, "R6 no irq while user reset enabled");
    tick();
    rdChk(2'd1, 1'b1, 32'h1, "R5 flag latched");
    rdChk(2'd1, 1'b1, 32'h0, "R5 read clears");

    // R4 enable off, R6 interrupt path
    wr(32'hA500_0010, 1'b0);
    push(2, 0, "R6 irq idle");
    padRstN = 1'b0;
    tick(); tick(); push(1, 0, "R4 no request when disabled");
    tick(); push(2, 1, "R6 irq raised");
    padRstN = 1'b1;
    tick(); tick(); tick(); push(2, 1, "R5 flag sticky");
    wr(32'hA500_0000, 1'b0); push(2, 0, "R6 irq masked by intEn");
    wr(32'hA500_0010, 1'b0); push(2, 1, "R6 irq re-enabled");
    wr(32'hA500_0011, 1'b0); push(2, 0, "R6 irq blocked by usrEn");
    wr(32'hA500_0010, 1'b0);
    rdChk(2'd1, 1'b1, 32'h1, "R5 status before clear");
    push(2, 0, "R6 irq after clear");
    rdChk(2'd1, 1'b0, 32'h0, "R5 status cleared");

    // R5 set wins over clear
    padRstN = 1'b0;
    tick(); tick(); tick();
    rdChk(2'd1, 1'b1, 32'h1, "R5 read during low");
    rdChk(2'd1, 1'b0, 32'h1, "R5 set beats clear");
    padRstN = 1'b1;
    tick(); tick(); tick();
    rdChk(2'd1, 1'b1, 32'h1, "R5 read after release");
    rdChk(2'd1, 1'b0, 32'h0, "R5 cleared after release");

    // R7 pulse lengths
    pulseChk(0, "R7 N=0");
    pulseChk(2, "R7 N=2");
    pulseChk(5, "R7 N=5");

    // R8 retrigger with new length
    wr(32'hA500_0300, 1'b0);
    extTrig = 1'b1; tick(); extTrig = 1'b0;
    for (int i = 0; i < 5; i++) begin
      push(3, 1, "R8 first pulse running");
      tick();
    end
    wr(32'hA500_0100, 1'b0);
    extTrig = 1'b1; tick(); extTrig = 1'b0;
    for (int j = 0; j < 6; j++) begin
      push(3, (j < 4) ? 32'd1 : 32'd0, "R8 reload from current N");
      tick();
    end

    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule